// File: doc/BRIEF.md
# Miss Target Queue with Upgrade Rewrite

This block holds the requesters waiting on a single outstanding cache miss, in arrival order. Each slot keeps a two-bit command, a requester identifier, an ordering tag, a ready time and a flag that marks the entry as coming from the processor side or from the memory side. Entries go in through a valid/ready push port. The oldest entry is always shown on a head port and leaves when the consumer raises pop ready.

Next to the storage the block keeps two sticky summary flags. One records that some processor-side requester wants exclusive ownership. The other records that some processor-side requester sent an upgrade. When an invalidating event makes upgrades impossible, the owner raises a rewrite pulse. In one cycle the block turns every stored upgrade into a read-exclusive request and drops the upgrade flag. A separate clear input resets both flags without touching the stored entries. An idle indicator reports that the queue is empty and both flags are low, so the miss handler can be recycled.

Commands use this encoding: 2'b00 read, 2'b01 read-exclusive, 2'b10 upgrade, 2'b11 writeback. Read-exclusive and upgrade both count as needing exclusive ownership.

Top module: `miss_target_queue`

## Requirements
- R1: A processor-side push (side bit 1) accepted with command 2'b01 or 2'b10 sets the exclusive flag. The flag stays set until a clear pulse. Rewrites and pops leave it alone.
- R2: A processor-side push accepted with command 2'b10 sets the upgrade flag. The flag stays set until a clear pulse or an effective rewrite.
- R3: A memory-side push (side bit 0) never changes either summary flag, whatever its command.
- R4: A rewrite pulse while the upgrade flag is low changes nothing. Stored 2'b10 entries stay 2'b10.
- R5: A rewrite pulse while the upgrade flag is high changes every stored 2'b10 command to 2'b01 in that cycle. Other commands and fields are kept. The upgrade flag is low afterwards.
- R6: A push accepted in the same cycle as a rewrite is stored exactly as presented, after the rewrite has been applied. Its flag effects from R1 and R2 still apply.
- R7: A clear pulse drops both flags and leaves the stored entries and their count unchanged. A push in the same cycle still sets flags per R1 and R2.
- R8: Entries come out in push order with command, identifier, order tag, ready time and side bit intact. Push ready is low only when DEPTH entries are held, and a push offered while full is not stored. Head valid is low when the queue is empty.
- R9: The idle indicator is high exactly when the queue holds no entry and both flags are low.
- R10: After reset the queue is empty, both flags are low and the idle indicator is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Push offer |
| push_ready | output | 1 | Queue can accept a push |
| push_cmd | input | 2 | Command of the pushed entry |
| push_id | input | ID_W | Requester identifier |
| push_order | input | ORDER_W | Ordering tag |
| push_time | input | TIME_W | Ready time |
| push_cpu | input | 1 | 1 = processor side, 0 = memory side |
| head_valid | output | 1 | Head entry present |
| pop_ready | input | 1 | Consumer takes the head entry |
| head_cmd | output | 2 | Head command |
| head_id | output | ID_W | Head identifier |
| head_order | output | ORDER_W | Head ordering tag |
| head_time | output | TIME_W | Head ready time |
| head_cpu | output | 1 | Head side bit |
| rewrite_req | input | 1 | Rewrite upgrades into read-exclusive |
| flag_clear | input | 1 | Clear both summary flags |
| excl_flag | output | 1 | Sticky exclusive-needed flag |
| upg_flag | output | 1 | Sticky upgrade-present flag |
| idle | output | 1 | Empty and both flags low |
| count | output | CNT_W | Number of stored entries |

## Verification
Every result is registered, so a push, pop, rewrite or clear presented before a rising edge shows on the head, flag, count and idle outputs one cycle later, just after that edge. The bench drives inputs on the falling edge, waits for the next rising edge and reads outputs a short delay after it, so each check sees exactly the state one cycle after its stimulus. Rewrite effects are checked by draining the queue and comparing each head against the expected converted or unconverted command.

// File: rtl/mtq_pkg.sv
package mtq_pkg;

    typedef enum logic [1:0] {
        CMD_RD  = 2'b00,
        CMD_RDX = 2'b01,
        CMD_UPG = 2'b10,
        CMD_WB  = 2'b11
    } cmd_e;

    function automatic logic wants_excl(input cmd_e c);
        return (c == CMD_RDX) || (c == CMD_UPG);
    endfunction

    function automatic cmd_e rewrite_cmd(input cmd_e c);
        return (c == CMD_UPG) ? CMD_RDX : c;
    endfunction

endpackage

// File: rtl/mtq_flags.sv
module mtq_flags
    import mtq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic push_fire,
    input  cmd_e push_cmd,
    input  logic push_cpu,
    input  logic rewrite_req,
    input  logic flag_clear,
    output logic rewrite_go,
    output logic excl_flag,
    output logic upg_flag
);

    logic set_excl, set_upg;
    logic excl_n, upg_n;

    assign set_excl   = push_fire && push_cpu && wants_excl(push_cmd);
    assign set_upg    = push_fire && push_cpu && (push_cmd == CMD_UPG);
    assign rewrite_go = rewrite_req && upg_flag;

    always_comb begin
        excl_n = flag_clear ? 1'b0 : excl_flag;
        upg_n  = (flag_clear || rewrite_go) ? 1'b0 : upg_flag;
        if (set_excl) excl_n = 1'b1;
        if (set_upg)  upg_n  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            excl_flag <= 1'b0;
            upg_flag  <= 1'b0;
        end else begin
            excl_flag <= excl_n;
            upg_flag  <= upg_n;
        end
    end

    p_excl_sticky_r1: assert property (@(posedge clk) disable iff (rst)
        (excl_flag && !flag_clear) |=> excl_flag);

    p_upg_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (push_fire && push_cpu && push_cmd == CMD_UPG) |=> (upg_flag && excl_flag));

    p_mem_side_r3: assert property (@(posedge clk) disable iff (rst)
        (push_fire && !push_cpu && !flag_clear && !rewrite_req)
        |=> ($stable(excl_flag) && $stable(upg_flag)));

    p_rewrite_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (rewrite_req && !(push_fire && push_cpu && push_cmd == CMD_UPG)) |=> !upg_flag);

    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (flag_clear && !push_fire) |=> (!excl_flag && !upg_flag));

endmodule

// File: rtl/mtq_store.sv
module mtq_store
    import mtq_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int ID_W    = 4,
    parameter int ORDER_W = 8,
    parameter int TIME_W  = 16,
    parameter int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               push_fire,
    input  cmd_e               push_cmd,
    input  logic [ID_W-1:0]    push_id,
    input  logic [ORDER_W-1:0] push_order,
    input  logic [TIME_W-1:0]  push_time,
    input  logic               push_cpu,
    input  logic               pop_fire,
    input  logic               rewrite_go,
    output cmd_e               head_cmd,
    output logic [ID_W-1:0]    head_id,
    output logic [ORDER_W-1:0] head_order,
    output logic [TIME_W-1:0]  head_time,
    output logic               head_cpu,
    output logic [CNT_W-1:0]   count
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        cmd_e               cmd;
        logic [ID_W-1:0]    id;
        logic [ORDER_W-1:0] order;
        logic [TIME_W-1:0]  rtime;
        logic               cpu;
    } entry_t;

    entry_t            slot [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    entry_t            push_ent;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign push_ent = '{cmd: push_cmd, id: push_id, order: push_order,
                        rtime: push_time, cpu: push_cpu};

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    slot[i] <= '0;
                end else if (push_fire && wr_ptr == PTR_W'(i)) begin
                    slot[i] <= push_ent;
                end else if (rewrite_go) begin
                    slot[i].cmd <= rewrite_cmd(slot[i].cmd);
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_fire) wr_ptr <= bump(wr_ptr);
            if (pop_fire)  rd_ptr <= bump(rd_ptr);
            case ({push_fire, pop_fire})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head_cmd   = slot[rd_ptr].cmd;
    assign head_id    = slot[rd_ptr].id;
    assign head_order = slot[rd_ptr].order;
    assign head_time  = slot[rd_ptr].rtime;
    assign head_cpu   = slot[rd_ptr].cpu;

    p_rewrite_head_r5: assert property (@(posedge clk) disable iff (rst)
        (rewrite_go && !push_fire && !pop_fire && count != 0 && head_cmd == CMD_UPG)
        |=> head_cmd == CMD_RDX);

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        push_fire |-> (count < CNT_W'(DEPTH) || pop_fire));

    p_no_underflow_r8: assert property (@(posedge clk) disable iff (rst)
        pop_fire |-> count != 0);

    p_noop_head_r4: assert property (@(posedge clk) disable iff (rst)
        (!rewrite_go && !push_fire && !pop_fire) |=> $stable(head_cmd));

endmodule

// File: rtl/miss_target_queue.sv
module miss_target_queue
    import mtq_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int ID_W    = 4,
    parameter int ORDER_W = 8,
    parameter int TIME_W  = 16,
    parameter int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               push_valid,
    output logic               push_ready,
    input  logic [1:0]         push_cmd,
    input  logic [ID_W-1:0]    push_id,
    input  logic [ORDER_W-1:0] push_order,
    input  logic [TIME_W-1:0]  push_time,
    input  logic               push_cpu,
    output logic               head_valid,
    input  logic               pop_ready,
    output logic [1:0]         head_cmd,
    output logic [ID_W-1:0]    head_id,
    output logic [ORDER_W-1:0] head_order,
    output logic [TIME_W-1:0]  head_time,
    output logic               head_cpu,
    input  logic               rewrite_req,
    input  logic               flag_clear,
    output logic               excl_flag,
    output logic               upg_flag,
    output logic               idle,
    output logic [CNT_W-1:0]   count
);

    logic push_fire, pop_fire, rewrite_go;
    cmd_e cmd_in, cmd_out;

    assign cmd_in     = cmd_e'(push_cmd);
    assign push_ready = (count != CNT_W'(DEPTH));
    assign head_valid = (count != '0);
    assign push_fire  = push_valid && push_ready;
    assign pop_fire   = pop_ready && head_valid;
    assign head_cmd   = cmd_out;

    mtq_flags u_flags (
        .clk         (clk),
        .rst         (rst),
        .push_fire   (push_fire),
        .push_cmd    (cmd_in),
        .push_cpu    (push_cpu),
        .rewrite_req (rewrite_req),
        .flag_clear  (flag_clear),
        .rewrite_go  (rewrite_go),
        .excl_flag   (excl_flag),
        .upg_flag    (upg_flag)
    );

    mtq_store #(
        .DEPTH   (DEPTH),
        .ID_W    (ID_W),
        .ORDER_W (ORDER_W),
        .TIME_W  (TIME_W),
        .CNT_W   (CNT_W)
    ) u_store (
        .clk        (clk),
        .rst        (rst),
        .push_fire  (push_fire),
        .push_cmd   (cmd_in),
        .push_id    (push_id),
        .push_order (push_order),
        .push_time  (push_time),
        .push_cpu   (push_cpu),
        .pop_fire   (pop_fire),
        .rewrite_go (rewrite_go),
        .head_cmd   (cmd_out),
        .head_id    (head_id),
        .head_order (head_order),
        .head_time  (head_time),
        .head_cpu   (head_cpu),
        .count      (count)
    );

    assign idle = !head_valid && !excl_flag && !upg_flag;

    p_idle_r9: assert property (@(posedge clk) disable iff (rst)
        idle |-> (count == '0 && !upg_flag));

    p_reset_r10: assert property (@(posedge clk)
        rst |=> (idle && count == '0));

endmodule

// File: tb/sim_miss_target_queue.sv
`timescale 1ns/1ps
module sim_miss_target_queue;

    localparam int DEPTH = 4, ID_W = 4, ORDER_W = 8, TIME_W = 16;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic clk = 1'b0, rst = 1'b1;
    logic push_valid = 0, push_cpu = 0, pop_ready = 0, rewrite_req = 0, flag_clear = 0;
    logic [1:0] push_cmd = 0;
    logic [ID_W-1:0] push_id = 0;
    logic [ORDER_W-1:0] push_order = 0;
    logic [TIME_W-1:0] push_time = 0;
    logic push_ready, head_valid, head_cpu, excl_flag, upg_flag, idle;
    logic [1:0] head_cmd;
    logic [ID_W-1:0] head_id;
    logic [ORDER_W-1:0] head_order;
    logic [TIME_W-1:0] head_time;
    logic [CNT_W-1:0] count;

    int checks = 0, fails = 0, cycles = 0;
    bit done = 0;

    always #10 clk = ~clk;

    miss_target_queue #(.DEPTH(DEPTH), .ID_W(ID_W), .ORDER_W(ORDER_W), .TIME_W(TIME_W)) u0 (
        .clk(clk), .rst(rst), .push_valid(push_valid), .push_ready(push_ready),
        .push_cmd(push_cmd), .push_id(push_id), .push_order(push_order),
        .push_time(push_time), .push_cpu(push_cpu), .head_valid(head_valid),
        .pop_ready(pop_ready), .head_cmd(head_cmd), .head_id(head_id),
        .head_order(head_order), .head_time(head_time), .head_cpu(head_cpu),
        .rewrite_req(rewrite_req), .flag_clear(flag_clear), .excl_flag(excl_flag),
        .upg_flag(upg_flag), .idle(idle), .count(count));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    // drive on falling edge, apply on rising edge, sample 1 ns later
    task automatic step();
        @(posedge clk); #1;
        push_valid = 0; pop_ready = 0; rewrite_req = 0; flag_clear = 0;
    endtask

    task automatic set_push(input logic [1:0] c, input int id, input int ord, input int t, input bit cpu);
        push_valid = 1; push_cmd = c; push_id = ID_W'(id);
        push_order = ORDER_W'(ord); push_time = TIME_W'(t); push_cpu = cpu;
    endtask

    task automatic push(input logic [1:0] c, input int id, input int ord, input int t, input bit cpu);
        @(negedge clk); set_push(c, id, ord, t, cpu); step();
    endtask

    task automatic pop_expect(input string req, input logic [1:0] c, input int id,
                              input int ord, input int t, input bit cpu);
        @(negedge clk);
        eq(req, int'(head_valid), 1);
        eq(req, int'(head_cmd), int'(c));
        eq(req, int'(head_id), id);
        eq(req, int'(head_order), ord);
        eq(req, int'(head_time), t);
        eq(req, int'(head_cpu), int'(cpu));
        pop_ready = 1; step();
    endtask

    task automatic pulse_rewrite();
        @(negedge clk); rewrite_req = 1; step();
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1; @(posedge clk); #1; rst = 0;
    endtask

    task automatic t_reset();
        do_reset();
        eq("R10 count", int'(count), 0);
        eq("R10 idle", int'(idle), 1);
        eq("R10 flags", int'({excl_flag, upg_flag}), 0);
        eq("R10 head_valid", int'(head_valid), 0);
    endtask

    task automatic t_cpu_flags();
        do_reset();
        push(2'b00, 1, 10, 100, 1);
        eq("R1 read leaves excl", int'(excl_flag), 0);
        eq("R9 idle low with entry", int'(idle), 0);
        push(2'b01, 2, 11, 101, 1);
        eq("R1 rdx sets excl", int'(excl_flag), 1);
        eq("R2 rdx no upg", int'(upg_flag), 0);
        push(2'b10, 3, 12, 102, 1);
        eq("R2 upg sets upg", int'(upg_flag), 1);
        pop_expect("R8 order", 2'b00, 1, 10, 100, 1);
        pop_expect("R8 order", 2'b01, 2, 11, 101, 1);
        pop_expect("R8 order", 2'b10, 3, 12, 102, 1);
        eq("R1 sticky after pops", int'(excl_flag), 1);
        eq("R9 idle low flags set", int'(idle), 0);
    endtask

    task automatic t_mem_side();
        do_reset();
        push(2'b10, 4, 20, 200, 0);
        push(2'b01, 5, 21, 201, 0);
        eq("R3 mem push no flags", int'({excl_flag, upg_flag}), 0);
        pulse_rewrite();
        pop_expect("R4 noop keeps upgrade", 2'b10, 4, 20, 200, 0);
        pop_expect("R4 noop keeps rdx", 2'b01, 5, 21, 201, 0);
        eq("R9 idle after drain", int'(idle), 1);
    endtask

    task automatic t_clear_then_noop();
        do_reset();
        push(2'b10, 6, 30, 300, 1);
        @(negedge clk); flag_clear = 1; step();
        eq("R7 clear flags", int'({excl_flag, upg_flag}), 0);
        eq("R7 count kept", int'(count), 1);
        pulse_rewrite();
        pop_expect("R4 noop after clear", 2'b10, 6, 30, 300, 1);
        eq("R9 idle empty clear", int'(idle), 1);
        // clear with simultaneous push: push flags win
        @(negedge clk); flag_clear = 1; set_push(2'b10, 7, 31, 301, 1); step();
        eq("R7 push beats clear", int'({excl_flag, upg_flag}), 3);
    endtask

    task automatic t_rewrite();
        do_reset();
        push(2'b00, 1, 40, 400, 1);
        push(2'b10, 2, 41, 401, 1);
        push(2'b11, 3, 42, 402, 0);
        push(2'b10, 4, 43, 403, 1);
        pulse_rewrite();
        eq("R5 upg cleared", int'(upg_flag), 0);
        eq("R1 excl kept by rewrite", int'(excl_flag), 1);
        pop_expect("R5 read kept", 2'b00, 1, 40, 400, 1);
        pop_expect("R5 upg->rdx", 2'b01, 2, 41, 401, 1);
        pop_expect("R5 wb kept", 2'b11, 3, 42, 402, 0);
        pop_expect("R5 upg->rdx", 2'b01, 4, 43, 403, 1);
    endtask

    task automatic t_rewrite_push();
        do_reset();
        push(2'b10, 1, 50, 500, 1);
        @(negedge clk); rewrite_req = 1; set_push(2'b10, 2, 51, 501, 1); step();
        eq("R6 push re-sets upg", int'(upg_flag), 1);
        eq("R6 count", int'(count), 2);
        pop_expect("R6 old converted", 2'b01, 1, 50, 500, 1);
        pop_expect("R6 new kept", 2'b10, 2, 51, 501, 1);
    endtask

    task automatic t_full();
        do_reset();
        for (int i = 0; i < DEPTH; i++) push(2'b00, i, 60 + i, 600 + i, 0);
        eq("R8 full ready low", int'(push_ready), 0);
        push(2'b11, 9, 99, 999, 0);
        eq("R8 no store when full", int'(count), DEPTH);
        for (int i = 0; i < DEPTH; i++) pop_expect("R8 full drain", 2'b00, i, 60 + i, 600 + i, 0);
        eq("R8 empty head_valid", int'(head_valid), 0);
        eq("R9 idle empty", int'(idle), 1);
    endtask

    initial begin
        t_reset();
        t_cpu_flags();
        t_mem_side();
        t_clear_then_noop();
        t_rewrite();
        t_rewrite_push();
        t_full();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000 && !done) begin
                done = 1;
                checks++; fails++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

endmodule